// File: doc/BRIEF.md
# JTAG Bus Bridge Master

This block turns simple parallel bus requests into JTAG traffic aimed at a single target device that contains a JTAG-to-internal-bus slave. It generates TCK from the system clock through a programmable divider. It walks the TAP state machine with TMS and shifts words out on TDI. It also collects the target's replies from TDO.

Before the bridge carries any traffic, an init command must be issued. The init command forces the TAP through Test-Logic-Reset into Run-Test/Idle, then loads the user instruction that selects the slave's data register. After init, every accepted request takes two data-register scans. The first scan carries a two-bit command prefix and the address. The second scan carries the write data, or a zero word for a read. During a read, the second scan brings back the value that the slave fetched in response to the first scan.

Top module: `jtag_bus_master`

## Requirements
- R1: While reset is held and just after it, `jtag_tck` is low, `req_ready` is low and `rsp_done` is low.
- R2: An init command drives at least five TCK cycles with TMS high, which puts the TAP in Test-Logic-Reset from any state. It then drives one cycle with TMS low to reach Run-Test/Idle. No shift state is entered before this. `req_ready` rises only after the instruction scan that follows has completed.
- R3: After the reset walk, the instruction register is loaded with `IR_VALUE`, which defaults to the 6-bit value 000010. The value is shifted LSB first in Shift-IR and the scan returns to Run-Test/Idle.
- R4: Every data-register scan shifts exactly max(`AW`,`DW`)+2 bits.
- R5: A write sends two scans. The first word has bits [top:top-1] = 11, the address in the low `AW` bits and zeros between. The second word has prefix 00, the write data in the low `DW` bits and zeros elsewhere.
- R6: A read sends a first word with prefix 10 and the address, then an all-zero word. `rsp_rdata` is the low `DW` bits of the word shifted out on TDO during that second scan.
- R7: Each TCK period lasts 2×`HALF_DIV` system clocks. TMS and TDI change only while TCK is low, at the falling edge.
- R8: TDI bits go out LSB first, and TDO is sampled at the rising TCK edge. The first sampled bit becomes bit 0 of the captured word.
- R9: A request is taken when `req_valid` and `req_ready` are both high, and `req_ready` then stays low until the access completes. `rsp_done` is high for exactly one system clock cycle, and `req_ready` is high again on that same cycle.
- R10: On completion of a write, `rsp_rdata` reads as zero.
- R11: If `init_req` and `req_valid` are both high while the bridge is ready, the request wins and no reset walk occurs. An init command on its own while ready drops `req_ready` and repeats the reset walk and the instruction load.
- R12: TCK stays low, with no edges, while no scan is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | 1 | Start TAP reset walk and instruction load |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Target register address |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read result, valid with `rsp_done` |
| jtag_tck | output | 1 | Test clock |
| jtag_tms | output | 1 | Test mode select |
| jtag_tdi | output | 1 | Serial data to the target |
| jtag_tdo | input | 1 | Serial data from the target |

## Verification
The bench builds the bridge with `AW`=10, `DW`=8 and `HALF_DIV`=2, which gives a 12-bit scan word. Because the address is wider than the data, the data word carries zero fill between the data field and the prefix. Reads can therefore show whether the result is taken from the right end of the captured word. With `HALF_DIV`=2 the divider uses its counting variant, so the bench can measure the TCK period and catch a TMS or TDI change during the high phase. The 6-bit instruction is shorter than the scan word, so a scan length mixed up between IR and DR shows up in the length the slave records.

// File: rtl/jtb_pkg.sv
package jtb_pkg;

   typedef enum logic [1:0] {
      OP_RESET = 2'd0,
      OP_IR    = 2'd1,
      OP_DR    = 2'd2
   } jtb_op_e;

   typedef enum logic [2:0] {
      C_OFF  = 3'd0,
      C_RST  = 3'd1,
      C_IR   = 3'd2,
      C_IDLE = 3'd3,
      C_CMD  = 3'd4,
      C_DAT  = 3'd5
   } jtb_ctl_e;

   localparam logic [1:0] PFX_RD   = 2'b10;
   localparam logic [1:0] PFX_WR   = 2'b11;
   localparam logic [1:0] PFX_DATA = 2'b00;

endpackage

// File: rtl/jtb_half_timer.sv
module jtb_half_timer #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   generate
      if (HALF == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(HALF);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               cnt_q <= '0;
            else if (!run || tick)    cnt_q <= '0;
            else                      cnt_q <= cnt_q + 1'b1;
         end

         assign tick = run && (cnt_q == CW'(HALF - 1));
      end
   endgenerate

endmodule

// File: rtl/jtb_scan_engine.sv
module jtb_scan_engine
   import jtb_pkg::*;
#(
   parameter int NW     = 12,
   parameter int DR_LEN = 12,
   parameter int IR_LEN = 6,
   parameter int RD_W   = 8,
   parameter int HALF   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  jtb_op_e         op,
   input  logic [NW-1:0]   data,
   output logic            done,
   output logic [RD_W-1:0] rd_low,
   output logic            tck,
   output logic            tms,
   output logic            tdi,
   input  logic            tdo
);

   localparam int MAXT = NW + 6;
   localparam int STW  = $clog2(MAXT + 1);

   logic            busy_q, done_q, tck_q, tms_q, tdi_q, tick;
   jtb_op_e         op_q;
   logic [NW-1:0]   dat_q, cap_q;
   logic [STW-1:0]  step_q, step_nx;

   function automatic logic [STW-1:0] pre_of(input jtb_op_e o);
      return (o == OP_IR) ? STW'(4) : STW'(3);
   endfunction

   function automatic logic [STW-1:0] len_of(input jtb_op_e o);
      case (o)
         OP_IR:   return STW'(IR_LEN);
         OP_DR:   return STW'(DR_LEN);
         default: return '0;
      endcase
   endfunction

   function automatic logic [STW-1:0] last_of(input jtb_op_e o);
      if (o == OP_RESET) return STW'(5);
      return pre_of(o) + len_of(o) + 1'b1;
   endfunction

   function automatic logic in_shift(input jtb_op_e o, input logic [STW-1:0] s);
      if (o == OP_RESET) return 1'b0;
      return (s >= pre_of(o)) && (s < pre_of(o) + len_of(o));
   endfunction

   function automatic logic tms_at(input jtb_op_e o, input logic [STW-1:0] s);
      logic [STW-1:0] p, n;
      p = pre_of(o);
      n = len_of(o);
      if (o == OP_RESET) return (s < STW'(5));
      if (s < p)         return (o == OP_IR) ? (s < STW'(2)) : (s == '0);
      if (s < p + n)     return (s == p + n - 1'b1);
      return (s == p + n);
   endfunction

   function automatic logic tdi_at(input jtb_op_e o, input logic [NW-1:0] d,
                                   input logic [STW-1:0] s);
      logic [NW-1:0] sh;
      sh = d >> (s - pre_of(o));
      return in_shift(o, s) ? sh[0] : 1'b0;
   endfunction

   jtb_half_timer #(.HALF(HALF)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy_q),
      .tick  (tick)
   );

   assign step_nx = step_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         tck_q  <= 1'b0;
         tms_q  <= 1'b0;
         tdi_q  <= 1'b0;
         op_q   <= OP_RESET;
         dat_q  <= '0;
         cap_q  <= '0;
         step_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               busy_q <= 1'b1;
               op_q   <= op;
               dat_q  <= data;
               step_q <= '0;
               tck_q  <= 1'b0;
               tms_q  <= tms_at(op, '0);
               tdi_q  <= tdi_at(op, data, '0);
               cap_q  <= '0;
            end
         end else if (tick) begin
            if (!tck_q) begin
               tck_q <= 1'b1;
               if (in_shift(op_q, step_q)) cap_q <= {tdo, cap_q[NW-1:1]};
            end else begin
               tck_q <= 1'b0;
               if (step_q == last_of(op_q)) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  step_q <= step_nx;
                  tms_q  <= tms_at(op_q, step_nx);
                  tdi_q  <= tdi_at(op_q, dat_q, step_nx);
               end
            end
         end
      end
   end

   assign done   = done_q;
   assign rd_low = cap_q[NW-DR_LEN +: RD_W];
   assign tck    = tck_q;
   assign tms    = tms_q;
   assign tdi    = tdi_q;

   p_tms_lowphase_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tms_q) |-> !tck_q);
   p_tdi_lowphase_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tdi_q) |-> !tck_q);
   p_tck_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !tck_q);
   p_tck_rise_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tck_q) |-> $past(tick));

endmodule

// File: rtl/jtb_seq_ctrl.sv
module jtb_seq_ctrl
   import jtb_pkg::*;
#(
   parameter int AW     = 6,
   parameter int DW     = 8,
   parameter int SW     = 10,
   parameter int NW     = 10,
   parameter int IR_LEN = 6,
   parameter logic [IR_LEN-1:0] IR_VALUE = 6'b000010
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           init_req,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic           req_write,
   input  logic [AW-1:0]  req_addr,
   input  logic [DW-1:0]  req_wdata,
   output logic           rsp_done,
   output logic [DW-1:0]  rsp_rdata,
   input  logic           eng_done,
   input  logic [DW-1:0]  eng_rd,
   output logic           eng_start,
   output jtb_op_e        eng_op,
   output logic [NW-1:0]  eng_data
);

   jtb_ctl_e       st_q;
   logic           wr_q;
   logic [DW-1:0]  wdata_q;

   function automatic logic [SW-1:0] cmd_word(input logic wr, input logic [AW-1:0] a);
      logic [SW-1:0] w;
      w = '0;
      w[SW-1:SW-2] = wr ? PFX_WR : PFX_RD;
      w[AW-1:0]    = a;
      return w;
   endfunction

   function automatic logic [SW-1:0] data_word(input logic [DW-1:0] d);
      logic [SW-1:0] w;
      w = '0;
      w[SW-1:SW-2] = PFX_DATA;
      w[DW-1:0]    = d;
      return w;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= C_OFF;
         wr_q      <= 1'b0;
         wdata_q   <= '0;
         rsp_done  <= 1'b0;
         rsp_rdata <= '0;
         eng_start <= 1'b0;
         eng_op    <= OP_RESET;
         eng_data  <= '0;
      end else begin
         eng_start <= 1'b0;
         rsp_done  <= 1'b0;
         case (st_q)
            C_OFF: if (init_req) begin
               st_q      <= C_RST;
               eng_start <= 1'b1;
               eng_op    <= OP_RESET;
               eng_data  <= '0;
            end
            C_RST: if (eng_done) begin
               st_q      <= C_IR;
               eng_start <= 1'b1;
               eng_op    <= OP_IR;
               eng_data  <= NW'(IR_VALUE);
            end
            C_IR: if (eng_done) st_q <= C_IDLE;
            C_IDLE: begin
               if (req_valid) begin
                  wr_q      <= req_write;
                  wdata_q   <= req_wdata;
                  st_q      <= C_CMD;
                  eng_start <= 1'b1;
                  eng_op    <= OP_DR;
                  eng_data  <= NW'(cmd_word(req_write, req_addr));
               end else if (init_req) begin
                  st_q      <= C_RST;
                  eng_start <= 1'b1;
                  eng_op    <= OP_RESET;
                  eng_data  <= '0;
               end
            end
            C_CMD: if (eng_done) begin
               st_q      <= C_DAT;
               eng_start <= 1'b1;
               eng_op    <= OP_DR;
               eng_data  <= NW'(data_word(wr_q ? wdata_q : '0));
            end
            C_DAT: if (eng_done) begin
               st_q      <= C_IDLE;
               rsp_done  <= 1'b1;
               rsp_rdata <= wr_q ? '0 : eng_rd;
            end
            default: st_q <= C_OFF;
         endcase
      end
   end

   assign req_ready = (st_q == C_IDLE);

   p_accept_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
   p_done_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> req_ready);
   p_ready_after_scan_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_ready) |-> $past(eng_done));
   p_start_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);

endmodule

// File: rtl/jtag_bus_master.sv
module jtag_bus_master
   import jtb_pkg::*;
#(
   parameter int AW       = 6,
   parameter int DW       = 8,
   parameter int IR_LEN   = 6,
   parameter logic [IR_LEN-1:0] IR_VALUE = 6'b000010,
   parameter int HALF_DIV = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           init_req,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic           req_write,
   input  logic [AW-1:0]  req_addr,
   input  logic [DW-1:0]  req_wdata,
   output logic           rsp_done,
   output logic [DW-1:0]  rsp_rdata,
   output logic           jtag_tck,
   output logic           jtag_tms,
   output logic           jtag_tdi,
   input  logic           jtag_tdo
);

   localparam int SW = ((AW > DW) ? AW : DW) + 2;
   localparam int NW = (SW > IR_LEN) ? SW : IR_LEN;

   generate
      if (AW < 1)       begin : g_bad_aw   $error("AW must be at least 1");       end
      if (DW < 1)       begin : g_bad_dw   $error("DW must be at least 1");       end
      if (IR_LEN < 2)   begin : g_bad_ir   $error("IR_LEN must be at least 2");   end
      if (HALF_DIV < 1) begin : g_bad_div  $error("HALF_DIV must be at least 1"); end
   endgenerate

   logic           eng_start, eng_done;
   jtb_op_e        eng_op;
   logic [NW-1:0]  eng_data;
   logic [DW-1:0]  eng_rd;

   jtb_seq_ctrl #(
      .AW(AW), .DW(DW), .SW(SW), .NW(NW), .IR_LEN(IR_LEN), .IR_VALUE(IR_VALUE)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_req  (init_req),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rsp_done  (rsp_done),
      .rsp_rdata (rsp_rdata),
      .eng_done  (eng_done),
      .eng_rd    (eng_rd),
      .eng_start (eng_start),
      .eng_op    (eng_op),
      .eng_data  (eng_data)
   );

   jtb_scan_engine #(
      .NW(NW), .DR_LEN(SW), .IR_LEN(IR_LEN), .RD_W(DW), .HALF(HALF_DIV)
   ) u_engine (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (eng_start),
      .op     (eng_op),
      .data   (eng_data),
      .done   (eng_done),
      .rd_low (eng_rd),
      .tck    (jtag_tck),
      .tms    (jtag_tms),
      .tdi    (jtag_tdi),
      .tdo    (jtag_tdo)
   );

endmodule

// File: tb/tb_jtag_bus_master.sv
`timescale 1ns/1ps
module tb_jtag_bus_master;

   localparam int AW   = 10;
   localparam int DW   = 8;
   localparam int HALF = 2;
   localparam int SW   = ((AW > DW) ? AW : DW) + 2;
   localparam logic [5:0] USER_IR = 6'b000010;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic init_req = 1'b0, req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rsp_done, jtag_tck, jtag_tms, jtag_tdi;
   logic [DW-1:0] rsp_rdata;
   logic jtag_tdo = 1'b0;

   always #2.5 clk = ~clk;

   jtag_bus_master #(.AW(AW), .DW(DW), .HALF_DIV(HALF)) dut (
      .clk(clk), .rst_n(rst_n), .init_req(init_req),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .jtag_tck(jtag_tck), .jtag_tms(jtag_tms), .jtag_tdi(jtag_tdi),
      .jtag_tdo(jtag_tdo)
   );

   // behavioural TAP slave with a bus-bridge data register
   typedef enum logic [3:0] {
      TLR, RTI, SELDR, CAPDR, SHDR, EX1DR, PAUDR, EX2DR, UPDDR,
      SELIR, CAPIR, SHIR, EX1IR, PAUIR, EX2IR, UPDIR
   } tap_e;

   function automatic tap_e nxt(input tap_e s, input logic m);
      case (s)
         TLR:   return m ? TLR   : RTI;
         RTI:   return m ? SELDR : RTI;
         SELDR: return m ? SELIR : CAPDR;
         CAPDR: return m ? EX1DR : SHDR;
         SHDR:  return m ? EX1DR : SHDR;
         EX1DR: return m ? UPDDR : PAUDR;
         PAUDR: return m ? EX2DR : PAUDR;
         EX2DR: return m ? UPDDR : SHDR;
         UPDDR: return m ? SELDR : RTI;
         SELIR: return m ? TLR   : CAPIR;
         CAPIR: return m ? EX1IR : SHIR;
         SHIR:  return m ? EX1IR : SHIR;
         EX1IR: return m ? UPDIR : PAUIR;
         PAUIR: return m ? EX2IR : PAUIR;
         EX2IR: return m ? UPDIR : SHIR;
         default: return m ? SELDR : RTI;
      endcase
   endfunction

   tap_e ts = PAUDR;
   logic [5:0] ir = 6'h3f, isr = '0;
   logic [SW-1:0] dsr = '0, w_prev = '0, w_last = '0;
   logic [DW-1:0] smem [1<<AW];
   logic [DW-1:0] emem [1<<AW];
   logic rd_flag = 1'b0, wr_flag = 1'b0;
   logic [AW-1:0] rd_addr = '0, wr_addr = '0;
   int tlr_cnt = 0, upd_cnt = 0, sh_cnt = 0, last_len = 0, early_shift = 0;
   int tck_rises = 0, hi_viol = 0;
   real last_rise = -1.0, min_per = 1.0e9;

   always @(posedge jtag_tck) begin
      if (last_rise >= 0.0 && ($realtime - last_rise) < min_per) min_per = $realtime - last_rise;
      last_rise = $realtime;
      tck_rises++;
      if ((ts == SHIR || ts == SHDR) && tlr_cnt == 0) early_shift++;
      if (nxt(ts, jtag_tms) == TLR && ts != TLR) tlr_cnt++;
      case (ts)
         TLR:   ir <= 6'h3f;
         CAPIR: isr <= 6'b000001;
         SHIR:  isr <= {jtag_tdi, isr[5:1]};
         UPDIR: ir <= isr;
         CAPDR: begin
            dsr <= (ir == USER_IR && rd_flag) ? SW'(smem[rd_addr]) : '0;
            sh_cnt = 0;
         end
         SHDR: begin
            dsr <= {jtag_tdi, dsr[SW-1:1]};
            sh_cnt++;
         end
         UPDDR: if (ir == USER_IR) begin
            w_prev <= w_last;
            w_last <= dsr;
            upd_cnt++;
            last_len = sh_cnt;
            case (dsr[SW-1:SW-2])
               2'b10: begin rd_flag <= 1'b1; rd_addr <= dsr[AW-1:0]; wr_flag <= 1'b0; end
               2'b11: begin wr_flag <= 1'b1; wr_addr <= dsr[AW-1:0]; rd_flag <= 1'b0; end
               2'b00: begin
                  if (wr_flag) smem[wr_addr] <= dsr[DW-1:0];
                  rd_flag <= 1'b0;
               end
               default: ;
            endcase
         end
         default: ;
      endcase
      ts <= nxt(ts, jtag_tms);
   end

   always @(negedge jtag_tck)
      jtag_tdo <= (ts == SHDR) ? dsr[0] : (ts == SHIR) ? isr[0] : 1'b0;

   // TMS/TDI must not move while TCK stays high
   logic s_tck = 1'b0, s_tms = 1'b0, s_tdi = 1'b0;
   always @(negedge clk) begin
      if (s_tck && jtag_tck && (s_tms != jtag_tms || s_tdi != jtag_tdi)) hi_viol++;
      s_tck = jtag_tck; s_tms = jtag_tms; s_tdi = jtag_tdi;
   end

   int tests = 0, fails = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [SW-1:0] exp_cmd(input bit wr, input logic [AW-1:0] a);
      logic [SW-1:0] w;
      w = '0;
      w[SW-1] = 1'b1;
      w[SW-2] = wr;
      w[AW-1:0] = a;
      return w;
   endfunction

   function automatic logic [SW-1:0] exp_dat(input bit wr, input logic [DW-1:0] d);
      logic [SW-1:0] w;
      w = '0;
      if (wr) w[DW-1:0] = d;
      return w;
   endfunction

   task automatic wait_ready();
      while (!req_ready) @(negedge clk);
   endtask

   task automatic finish_access(input bit wr, input logic [AW-1:0] a,
                                input logic [DW-1:0] d, input int upd0);
      logic [DW-1:0] expd;
      while (!rsp_done) @(negedge clk);
      expd = wr ? '0 : emem[a];
      if (wr) chk(rsp_rdata == expd, "R10 write rdata zero", rsp_rdata, expd);
      else    chk(rsp_rdata == expd, "R6 R8 read data", rsp_rdata, expd);
      chk(req_ready == 1'b1, "R9 ready with done", req_ready, 1);
      chk(upd_cnt == upd0 + 2, "R5 R6 two scans", upd_cnt, upd0 + 2);
      if (wr) begin
         chk(w_prev == exp_cmd(1, a), "R5 write cmd word", w_prev, exp_cmd(1, a));
         chk(w_last == exp_dat(1, d), "R5 write data word", w_last, exp_dat(1, d));
         emem[a] = d;
      end else begin
         chk(w_prev == exp_cmd(0, a), "R6 read cmd word", w_prev, exp_cmd(0, a));
         chk(w_last == '0, "R6 read zero word", w_last, 0);
      end
      chk(last_len == SW, "R4 scan length", last_len, SW);
      @(negedge clk);
      chk(rsp_done == 1'b0, "R9 done one cycle", rsp_done, 0);
   endtask

   task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      int upd0;
      wait_ready();
      upd0 = upd_cnt;
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R9 ready drops", req_ready, 0);
      finish_access(wr, a, d, upd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int seed, r0, t0;
      seed = $urandom(32'h1d2c);
      for (int i = 0; i < (1 << AW); i++) begin smem[i] = '0; emem[i] = '0; end

      repeat (4) @(negedge clk);
      chk(jtag_tck == 1'b0, "R1 tck low in reset", jtag_tck, 0);
      chk(req_ready == 1'b0, "R1 ready low in reset", req_ready, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(rsp_done == 1'b0, "R1 done low", rsp_done, 0);
      chk(req_ready == 1'b0, "R2 not ready before init", req_ready, 0);
      chk(tck_rises == 0, "R12 no tck before init", tck_rises, 0);

      init_req = 1'b1; @(negedge clk); init_req = 1'b0;
      wait_ready();
      chk(tlr_cnt == 1, "R2 reached reset state", tlr_cnt, 1);
      chk(early_shift == 0, "R2 no shift before reset", early_shift, 0);
      chk(ts == RTI, "R2 R3 back in idle", ts, RTI);
      chk(ir == USER_IR, "R3 instruction loaded", ir, USER_IR);

      // directed corners
      access(1, {AW{1'b1}}, 8'hA5);
      access(0, {AW{1'b1}}, 8'h00);
      access(1, '0, 8'h81);
      access(0, '0, 8'h00);
      access(0, 10'h155, 8'h00);
      access(1, 10'h200, 8'hFF);
      access(1, 10'h200, 8'h01);
      access(0, 10'h200, 8'h00);

      // constrained random traffic on a small address window
      for (int k = 0; k < 40; k++) begin
         logic [AW-1:0] a;
         a = AW'($urandom_range(0, 15));
         if ($urandom_range(0, 1) == 1) a[AW-1] = 1'b1;
         access(($urandom_range(0, 2) != 0) ? 1'b0 : 1'b1, a, DW'($urandom));
      end

      // R11: request and init together, request wins
      wait_ready();
      t0 = tlr_cnt; r0 = upd_cnt;
      init_req = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = '0;
      @(negedge clk);
      init_req = 1'b0; req_valid = 1'b0;
      finish_access(0, '0, 8'h00, r0);
      chk(tlr_cnt == t0, "R11 request beats init", tlr_cnt, t0);

      // R11: init alone while ready
      wait_ready();
      init_req = 1'b1; @(negedge clk); init_req = 1'b0;
      chk(req_ready == 1'b0, "R11 init drops ready", req_ready, 0);
      wait_ready();
      chk(tlr_cnt == t0 + 1, "R11 reset walk repeated", tlr_cnt, t0 + 1);
      chk(ir == USER_IR, "R11 R3 instruction reloaded", ir, USER_IR);
      access(0, {AW{1'b1}}, 8'h00);

      r0 = tck_rises;
      repeat (40) @(negedge clk);
      chk(tck_rises == r0, "R12 tck quiet when idle", tck_rises, r0);
      chk(jtag_tck == 1'b0, "R12 tck parked low", jtag_tck, 0);
      chk(hi_viol == 0, "R7 tms tdi stable while tck high", hi_viol, 0);
      chk(min_per > 2.0 * HALF * 5.0 - 0.01 && min_per < 2.0 * HALF * 5.0 + 0.01,
          "R7 tck period", longint'(min_per * 1000.0), longint'(2.0 * HALF * 5000.0));

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule